// File: doc/BRIEF.md
# Double-Edge PWM Interval Decoder

This block receives a two-level line on which data are carried by timing rather than by voltage. Each stretch between two consecutive transitions, whether the line sits high or low, carries one symbol. The symbol is the stretch length in clock ticks minus a fixed minimum width. The line is produced by a transmitter that runs from the same tick clock, so the time step is exactly one tick and no clock recovery is needed.

The raw line first passes through a synchronizer chain. A transition detector then closes the running measurement and restarts a saturating tick counter. The closed length is checked against the legal window `[MIN_TICKS, MIN_TICKS + LEVELS - 1]`. A legal length produces a one-cycle `sym_valid` with `sym_data = length - MIN_TICKS` and the level of the stretch that just ended. An illegal length produces a one-cycle error pulse with a coded reason. A line that stays quiet for too long reports one timeout and is then re-armed by the next transition.

Top module: `pwm_interval_decoder`

## Requirements
- R1: The line passes through two synchronizer flops, and a transition first sampled at rising edge k shows its result on the outputs just after rising edge k+2. Nothing is emitted unless the sampled line changed at that sample or a timeout occurred.
- R2: For a closed stretch of length L ticks (the number of rising edges between two consecutive sampled transitions) with MIN_TICKS <= L <= MIN_TICKS+LEVELS-1, `sym_valid` is high for one cycle and `sym_data` equals L - MIN_TICKS.
- R3: High and low stretches decode the same way. With every closed-stretch result, `sym_level` gives the level of the stretch that ended (1 = high).
- R4: A closed stretch with L < MIN_TICKS gives a one-cycle `err_pulse` with `err_code` = 1 and no `sym_valid`.
- R5: A closed stretch with MIN_TICKS+LEVELS-1 < L <= QUIET_TICKS gives a one-cycle `err_pulse` with `err_code` = 2 and no `sym_valid`.
- R6: When QUIET_TICKS ticks pass after a measured transition with no new one, a single `err_pulse` with `err_code` = 3 is raised. The next transition only restarts measurement and emits nothing.
- R7: After reset, all outputs are 0. The first transition after reset only starts a measurement and emits nothing.
- R8: `sym_valid` and `err_pulse` are never high together. `err_code` is 0 whenever `err_pulse` is low and nonzero whenever it is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Tick clock shared with the transmitter |
| rst | input | 1 | Synchronous active-high reset |
| line_in | input | 1 | Raw two-level modulated line |
| sym_valid | output | 1 | One-cycle strobe for a decoded symbol |
| sym_data | output | $clog2(LEVELS) | Decoded symbol value |
| sym_level | output | 1 | Level of the stretch that just closed |
| err_pulse | output | 1 | One-cycle strobe for a rejected stretch or a timeout |
| err_code | output | 2 | 0 none, 1 too short, 2 too long, 3 quiet timeout |

## Verification
A wrong count or a miswired restart shows up as a symbol value that is off by a constant on the very first closed stretch, three cycles after the transition. A stuck or mis-set arming flag shows up as a symbol emitted for the first transition after reset or after a timeout, or as repeated timeouts on a silent line. A wrong level register shows as inverted `sym_level` on alternate symbols. Because the reference model predicts every output on every cycle, each such fault is caught on the first cycle whose output differs.

// File: rtl/dpwm_dec_pkg.sv
package dpwm_dec_pkg;

    // Reason attached to an emitted interval result
    typedef enum logic [1:0] {
        FLT_NONE  = 2'd0,
        FLT_SHORT = 2'd1,
        FLT_LONG  = 2'd2,
        FLT_QUIET = 2'd3
    } fault_e;

    // Per-cycle decision of the interval judge
    typedef struct packed {
        logic   emit;   // something reaches the outputs next cycle
        logic   good;   // a legal symbol
        logic   closed; // result belongs to a closed stretch (has a level)
        fault_e fault;
    } verdict_t;

    function automatic fault_e classify_len(input int unsigned len,
                                            input int unsigned lo,
                                            input int unsigned hi);
        if (len < lo)      return FLT_SHORT;
        else if (len > hi) return FLT_LONG;
        else               return FLT_NONE;
    endfunction

endpackage

// File: rtl/dpwm_line_sync.sv
module dpwm_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic line_in,
    output logic level_prev,
    output logic edge_seen
);

    logic [STAGES-1:0] chain;
    logic              level_now;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) chain <= '0;
                else     chain <= line_in;
            end
        end else begin : g_multi
            always_ff @(posedge clk) begin
                if (rst) chain <= '0;
                else     chain <= {chain[STAGES-2:0], line_in};
            end
        end
    endgenerate

    assign level_now = chain[STAGES-1];

    always_ff @(posedge clk) begin
        if (rst) level_prev <= 1'b0;
        else     level_prev <= level_now;
    end

    assign edge_seen = level_now ^ level_prev;

endmodule

// File: rtl/dpwm_tick_counter.sv
module dpwm_tick_counter #(
    parameter int LIMIT = 24,
    parameter int CW    = $clog2(LIMIT + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          restart,
    output logic [CW-1:0] count,
    output logic          at_limit
);

    localparam logic [CW-1:0] TOP = CW'(LIMIT);

    always_ff @(posedge clk) begin
        if (rst)                count <= TOP;
        else if (restart)       count <= CW'(1);
        else if (count != TOP)  count <= count + CW'(1);
    end

    assign at_limit = (count == TOP);

endmodule

// File: rtl/dpwm_interval_judge.sv
module dpwm_interval_judge
    import dpwm_dec_pkg::*;
#(
    parameter int MIN_TICKS = 4,
    parameter int LEVELS    = 8,
    parameter int CW        = 5,
    parameter int SW        = 3
) (
    input  logic [CW-1:0] len,
    input  logic          edge_seen,
    input  logic          armed,
    input  logic          at_limit,
    output verdict_t      verdict,
    output logic [SW-1:0] sym
);

    localparam int unsigned LO = MIN_TICKS;
    localparam int unsigned HI = MIN_TICKS + LEVELS - 1;
    localparam logic [CW-1:0] BASE = CW'(MIN_TICKS);

    logic [CW-1:0] offset;
    assign offset = len - BASE;
    assign sym    = SW'(offset);

    always_comb begin
        verdict = '0;
        if (edge_seen && armed) begin
            verdict.emit   = 1'b1;
            verdict.closed = 1'b1;
            verdict.fault  = classify_len(32'(len), LO, HI);
            verdict.good   = (verdict.fault == FLT_NONE);
        end else if (!edge_seen && armed && at_limit) begin
            verdict.emit  = 1'b1;
            verdict.fault = FLT_QUIET;
        end
    end

endmodule

// File: rtl/pwm_interval_decoder.sv
module pwm_interval_decoder
    import dpwm_dec_pkg::*;
#(
    parameter  int MIN_TICKS   = 4,
    parameter  int LEVELS      = 8,
    parameter  int QUIET_TICKS = 24,
    parameter  int SYNC_STAGES = 2,
    localparam int SW          = $clog2(LEVELS),
    localparam int CW          = $clog2(QUIET_TICKS + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          line_in,
    output logic          sym_valid,
    output logic [SW-1:0] sym_data,
    output logic          sym_level,
    output logic          err_pulse,
    output logic [1:0]    err_code
);

    logic          level_prev;
    logic          edge_seen;
    logic [CW-1:0] count;
    logic          at_limit;
    logic          armed;
    verdict_t      verdict;
    logic [SW-1:0] sym;

    dpwm_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst       (rst),
        .line_in   (line_in),
        .level_prev(level_prev),
        .edge_seen (edge_seen)
    );

    dpwm_tick_counter #(.LIMIT(QUIET_TICKS), .CW(CW)) u_count (
        .clk     (clk),
        .rst     (rst),
        .restart (edge_seen),
        .count   (count),
        .at_limit(at_limit)
    );

    dpwm_interval_judge #(
        .MIN_TICKS(MIN_TICKS),
        .LEVELS   (LEVELS),
        .CW       (CW),
        .SW       (SW)
    ) u_judge (
        .len      (count),
        .edge_seen(edge_seen),
        .armed    (armed),
        .at_limit (at_limit),
        .verdict  (verdict),
        .sym      (sym)
    );

    // Any transition arms measurement; a timeout disarms it
    always_ff @(posedge clk) begin
        if (rst)                       armed <= 1'b0;
        else if (edge_seen)            armed <= 1'b1;
        else if (armed && at_limit)    armed <= 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sym_valid <= 1'b0;
            sym_data  <= '0;
            sym_level <= 1'b0;
            err_pulse <= 1'b0;
            err_code  <= FLT_NONE;
        end else begin
            sym_valid <= verdict.emit && verdict.good;
            err_pulse <= verdict.emit && !verdict.good;
            err_code  <= (verdict.emit && !verdict.good) ? verdict.fault : FLT_NONE;
            if (verdict.emit && verdict.good) sym_data  <= sym;
            if (verdict.closed)               sym_level <= level_prev;
        end
    end

endmodule

// File: rtl/pwm_interval_decoder_checker.sv
module pwm_interval_decoder_checker #(
    parameter int MIN_TICKS = 4
) (
    input logic       clk,
    input logic       rst,
    input logic       line_in,
    input logic       sym_valid,
    input logic       err_pulse,
    input logic [1:0] err_code
);

    a_r8_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(sym_valid && err_pulse));

    a_r8_idle_code: assert property (@(posedge clk) disable iff (rst)
        !err_pulse |-> err_code == 2'd0);

    a_r8_err_code: assert property (@(posedge clk) disable iff (rst)
        err_pulse |-> err_code != 2'd0);

    // R1: a closed-stretch result needs a line change three samples back
    a_r1_after_transition: assert property (@(posedge clk) disable iff (rst)
        (sym_valid || (err_pulse && err_code != 2'd3))
            |-> $past(line_in, 3) != $past(line_in, 4));

    a_r6_quiet_line: assert property (@(posedge clk) disable iff (rst)
        (err_pulse && err_code == 2'd3) |-> $past(line_in, 3) == $past(line_in, 4));

    a_r6_single_timeout: assert property (@(posedge clk) disable iff (rst)
        (err_pulse && err_code == 2'd3) |=> !err_pulse);

    generate
        if (MIN_TICKS > 1) begin : g_spacing
            a_r2_spacing: assert property (@(posedge clk) disable iff (rst)
                sym_valid |=> !sym_valid);
        end
    endgenerate

endmodule

bind pwm_interval_decoder pwm_interval_decoder_checker #(.MIN_TICKS(MIN_TICKS)) u_checker (
    .clk      (clk),
    .rst      (rst),
    .line_in  (line_in),
    .sym_valid(sym_valid),
    .err_pulse(err_pulse),
    .err_code (err_code)
);

// File: tb/tb_pwm_interval_decoder.sv
module tb_pwm_interval_decoder;

    localparam int MIN_TICKS   = 4;
    localparam int LEVELS      = 8;
    localparam int QUIET_TICKS = 24;
    localparam int SW          = $clog2(LEVELS);

    logic          clk;
    logic          rst;
    logic          line_in;
    logic          sym_valid;
    logic [SW-1:0] sym_data;
    logic          sym_level;
    logic          err_pulse;
    logic [1:0]    err_code;

    pwm_interval_decoder #(
        .MIN_TICKS  (MIN_TICKS),
        .LEVELS     (LEVELS),
        .QUIET_TICKS(QUIET_TICKS)
    ) dut (
        .clk      (clk),
        .rst      (rst),
        .line_in  (line_in),
        .sym_valid(sym_valid),
        .sym_data (sym_data),
        .sym_level(sym_level),
        .err_pulse(err_pulse),
        .err_code (err_code)
    );

    initial clk = 1'b0;
    always #5 clk = ~clk;

    typedef struct {
        bit v;
        bit e;
        int code;
        int data;
        bit lvl;
    } ev_t;

    int  checks = 0;
    int  errors = 0;
    int  cyc    = 0;
    int  last_k = 0;
    bit  armed  = 0;
    bit  m_prev = 0;
    bit  done   = 0;
    ev_t pipe[$];

    int sweep[8] = '{4, 11, 5, 10, 6, 9, 7, 8};
    int fast[4]  = '{2, 1, 3, 6};
    int slow[4]  = '{12, 20, 24, 5};

    function automatic string tag_of(ev_t x);
        if (x.v)            return "R2";
        else if (x.code==1) return "R4";
        else if (x.code==2) return "R5";
        else if (x.code==3) return "R6";
        else                return "R8";
    endfunction

    task automatic compare(ev_t x);
        checks++;
        if (sym_valid !== x.v || err_pulse !== x.e || err_code !== 2'(x.code)) begin
            errors++;
            $display("FAIL %s (timing R1) cyc %0d: valid=%0b err=%0b code=%0d expected valid=%0b err=%0b code=%0d",
                     tag_of(x), cyc, sym_valid, err_pulse, err_code, x.v, x.e, x.code);
        end else if (x.v) begin
            checks++;
            if (sym_data !== SW'(x.data)) begin
                errors++;
                $display("FAIL R2 cyc %0d: sym_data=%0d expected %0d", cyc, sym_data, x.data);
            end
            checks++;
            if (sym_level !== x.lvl) begin
                errors++;
                $display("FAIL R3 cyc %0d: sym_level=%0b expected %0b", cyc, sym_level, x.lvl);
            end
        end else if (x.e && x.code != 3) begin
            checks++;
            if (sym_level !== x.lvl) begin
                errors++;
                $display("FAIL R3 cyc %0d: sym_level=%0b expected %0b (error stretch)", cyc, sym_level, x.lvl);
            end
        end
    endtask

    // One tick: check outputs, model the sample just taken, drive the next value
    task automatic step(input logic nxt);
        ev_t n;
        ev_t z;
        int  len;
        @(negedge clk);
        cyc++;
        z = '{default: 0};
        n = '{default: 0};
        if (rst) begin
            pipe.delete();
            pipe.push_back(z);
            pipe.push_back(z);
        end
        compare(pipe.pop_front());
        if (rst) begin
            m_prev = 0;
            armed  = 0;
        end else begin
            if (line_in != m_prev) begin
                if (armed) begin
                    len   = cyc - last_k;
                    n.lvl = m_prev;
                    if (len < MIN_TICKS) begin
                        n.e = 1; n.code = 1;
                    end else if (len > MIN_TICKS + LEVELS - 1) begin
                        n.e = 1; n.code = 2;
                    end else begin
                        n.v = 1; n.data = len - MIN_TICKS;
                    end
                end
                armed  = 1;  // R7: first transition only starts a measurement
                last_k = cyc;
            end else if (armed && (cyc - last_k == QUIET_TICKS)) begin
                n.e = 1; n.code = 3;
                armed = 0;
            end
            m_prev = line_in;
        end
        pipe.push_back(n);
        line_in = nxt;
    endtask

    task automatic hold(input logic v, input int cnt);
        repeat (cnt) step(v);
    endtask

    initial begin
        logic lv;
        rst     = 1'b1;
        line_in = 1'b0;
        hold(1'b0, 4);
        rst = 1'b0;
        // R7: reset state at the ports
        checks++;
        if (sym_valid !== 1'b0 || err_pulse !== 1'b0 || err_code !== 2'd0 ||
            sym_data !== '0 || sym_level !== 1'b0) begin
            errors++;
            $display("FAIL R7: after reset valid=%0b err=%0b code=%0d data=%0d lvl=%0b expected all 0",
                     sym_valid, err_pulse, err_code, sym_data, sym_level);
        end
        hold(1'b0, 5);
        // R7: this first rise only arms the decoder
        hold(1'b1, 7);
        lv = 1'b0;
        // R2/R3: every symbol, alternating polarity
        foreach (sweep[i]) begin
            hold(lv, sweep[i]);
            lv = ~lv;
        end
        // R4: short stretches, then a legal one
        foreach (fast[i]) begin
            hold(lv, fast[i]);
            lv = ~lv;
        end
        // R5: long stretches, including exactly the quiet limit
        foreach (slow[i]) begin
            hold(lv, slow[i]);
            lv = ~lv;
        end
        // R6: silence, then a restart with no output, then a symbol
        hold(lv, 40);
        lv = ~lv;
        hold(lv, 5);
        lv = ~lv;
        hold(lv, 6);
        lv = ~lv;
        hold(lv, 9);
        lv = ~lv;
        // R6: silence while low as well
        hold(lv, 35);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: run did not finish, actual timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule